// File: doc/BRIEF.md
# Frame Preemption Verify Controller

This block runs per Ethernet port and decides whether frame preemption may be used on the link. Preemption means that express traffic may interrupt a preemptable frame. The block either runs a verify/response handshake with the link partner or, in forced mode, skips the handshake. It asks the MAC to transmit verify frames and response frames. It retries a verify that gets no answer and reports the handshake state. It also drives a single flag that tells the transmit path preemption is in force.

Software sets two levels of enable: a global one for the whole switch and one for the port. It holds a link-fail bit while the link is not usable. When that bit is cleared, verification starts at once. The verify timeout is a 24-bit count of prescaled ticks rather than of clock cycles, so one count setting can serve any link speed. The tick divider is the parameter `TICK_DIV`, with a default of 4.

The state machine has five states, reported on `hs_state`:

| State | Code | Meaning |
|---|---|---|
| DISABLED | 0 | An enable is low. |
| INIT | 1 | Link held failed, or forced mode. |
| VERIFYING | 2 | Waiting for a response. |
| SUCCEEDED | 3 | Handshake passed. |
| FAILED | 4 | All attempts used up. |

The transitions are:

- Any state goes to DISABLED when an enable drops.
- Any enabled state goes to INIT when link-fail or forced mode is set.
- DISABLED goes to INIT once both enables are high.
- INIT goes to VERIFYING on entry to the handshake.
- VERIFYING goes to VERIFYING on a retry after an expired timer.
- VERIFYING goes to SUCCEEDED on a response.
- VERIFYING goes to FAILED when the timer expires with no retries left.

Top module: `fp_verify_ctrl`

## Requirements
- R1: After reset `hs_state` is DISABLED (code 0), and `send_verify`, `send_response` and `preempt_active` are all 0.
- R2: While `glb_en` or `port_en` is low, `hs_state` reads DISABLED (0) from the following cycle on. Once both are high, the block leaves DISABLED on the next edge.
- R3: In the cycle after `link_fail` was high, `send_verify` and `send_response` are 0. While both enables are high, `hs_state` is INIT (1).
- R4: With both enables high and `force_mode` low, the cycle after `link_fail` falls shows `hs_state` = VERIFYING (2) and a one-cycle `send_verify` pulse. The timer is loaded from `verify_count` at the same edge.
- R5: If no response comes, the next `send_verify` pulse follows exactly `verify_count`*`TICK_DIV`+1 cycles after the previous one. This happens for up to 3 retries, so there are 4 pulses in all. The same delay after the fourth pulse ends in FAILED (4) with no further pulse.
- R6: A `rx_response` strobe in VERIFYING moves the block to SUCCEEDED (3) on the next edge. The strobe wins over a timer expiring in the same cycle.
- R7: In forced mode (`force_mode` high), `send_verify` stays 0, `hs_state` stays INIT (1) while enabled, and `verify_count` has no effect.
- R8: A `rx_verify` strobe gives a one-cycle `send_response` pulse on the next cycle, in any state. This requires both enables high, `link_fail` low and `force_mode` low; otherwise no pulse follows.
- R9: `preempt_active` equals `pre_en` AND `glb_en` AND `port_en` AND (state is SUCCEEDED, or `force_mode` is high). `pre_en` has no effect while `glb_en` is low.
- R10: Raising `link_fail` in SUCCEEDED or FAILED returns the block to INIT (1) on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_en | input | 1 | Global preemption enable |
| port_en | input | 1 | Per-port preemption enable |
| pre_en | input | 1 | Allows express traffic to interrupt preemptable frames |
| force_mode | input | 1 | Skips the verify handshake |
| link_fail | input | 1 | Software-held link failure; blocks verify and response frames |
| verify_count | input | 24 | Verify timeout in prescaled ticks |
| rx_verify | input | 1 | Strobe: a verify frame was received |
| rx_response | input | 1 | Strobe: a response frame was received |
| send_verify | output | 1 | One-cycle request to transmit a verify frame |
| send_response | output | 1 | One-cycle request to transmit a response frame |
| hs_state | output | 3 | Handshake state code |
| preempt_active | output | 1 | Preemption is in force on this port |

## Verification
The in-RTL assertions check the following on every cycle:

- No frame request follows a cycle with `link_fail` or `force_mode` high.
- `preempt_active` never rises without all three enables.
- The retry count stays within bound.
- FAILED is reached only from VERIFYING.
- The timer never counts upward without a load.

The bench scenarios cover the timing that only scenarios can show: the exact pulse spacing for each count, the number of retries before FAILED, the priority of a response over an expiring timer, and whether a response request follows a received verify across random enable and link settings.

// File: rtl/fp_verify_pkg.sv
package fp_verify_pkg;

    typedef enum logic [2:0] {
        ST_DISABLED  = 3'd0,
        ST_INIT      = 3'd1,
        ST_VERIFYING = 3'd2,
        ST_SUCCEEDED = 3'd3,
        ST_FAILED    = 3'd4
    } hs_state_e;

endpackage

// File: rtl/fp_verify_timer.sv
module fp_verify_timer #(
    parameter int CNT_W    = 24,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    generate
        if (TICK_DIV > 1) begin : g_prescale
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (load)
                    pre_q <= '0;
                else if (run)
                    pre_q <= (pre_q == PW'(TICK_DIV - 1)) ? '0 : pre_q + 1'b1;
            end
            assign tick = run && (pre_q == PW'(TICK_DIV - 1));
        end else begin : g_noprescale
            assign tick = run;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q == '0);

    // R5: the timer only moves down between loads
    a_r5_timer_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/fp_verify_fsm.sv
module fp_verify_fsm
    import fp_verify_pkg::*;
#(
    parameter int MAX_RETRY = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enabled,
    input  logic      link_fail,
    input  logic      force_mode,
    input  logic      rx_verify,
    input  logic      rx_response,
    input  logic      expired,
    output hs_state_e state,
    output logic      timer_load,
    output logic      timer_run,
    output logic      send_verify,
    output logic      send_response
);
    localparam int RW = $clog2(MAX_RETRY + 1) + 1;

    hs_state_e      state_q, state_d;
    logic [RW-1:0]  retry_q;
    logic           first_load, retry_load;

    always_comb begin
        state_d = state_q;
        if (!enabled)
            state_d = ST_DISABLED;
        else if (link_fail || force_mode)
            state_d = ST_INIT;
        else begin
            unique case (state_q)
                ST_DISABLED:  state_d = ST_INIT;
                ST_INIT:      state_d = ST_VERIFYING;
                ST_VERIFYING: begin
                    if (rx_response)
                        state_d = ST_SUCCEEDED;
                    else if (expired && retry_q == RW'(MAX_RETRY))
                        state_d = ST_FAILED;
                end
                ST_SUCCEEDED: state_d = ST_SUCCEEDED;
                ST_FAILED:    state_d = ST_FAILED;
                default:      state_d = ST_DISABLED;
            endcase
        end
    end

    assign first_load = (state_q != ST_VERIFYING) && (state_d == ST_VERIFYING);
    assign retry_load = (state_q == ST_VERIFYING) && (state_d == ST_VERIFYING) && expired;
    assign timer_load = first_load || retry_load;
    assign timer_run  = (state_q == ST_VERIFYING);
    assign state      = state_q;

    // state register and retry count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DISABLED;
            retry_q <= '0;
        end else begin
            state_q <= state_d;
            if (first_load)
                retry_q <= '0;
            else if (retry_load)
                retry_q <= retry_q + 1'b1;
        end
    end

    // frame request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            send_verify   <= 1'b0;
            send_response <= 1'b0;
        end else begin
            send_verify   <= timer_load;
            send_response <= rx_verify && enabled && !link_fail && !force_mode;
        end
    end

    a_r3_no_tx_after_link_fail: assert property (@(posedge clk) disable iff (!rst_n)
        $past(link_fail) |-> (!send_verify && !send_response));

    a_r7_forced_no_verify: assert property (@(posedge clk) disable iff (!rst_n)
        $past(force_mode) |-> !send_verify);

    a_r5_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        retry_q <= RW'(MAX_RETRY));

    a_r5_fail_from_verifying: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILED && $past(state_q) != ST_FAILED) |-> $past(state_q) == ST_VERIFYING);

    a_r2_disabled_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enabled) |-> state_q == ST_DISABLED);

endmodule

// File: rtl/fp_verify_ctrl.sv
module fp_verify_ctrl
    import fp_verify_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int TICK_DIV  = 4,
    parameter int MAX_RETRY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic             port_en,
    input  logic             pre_en,
    input  logic             force_mode,
    input  logic             link_fail,
    input  logic [CNT_W-1:0] verify_count,
    input  logic             rx_verify,
    input  logic             rx_response,
    output logic             send_verify,
    output logic             send_response,
    output logic [2:0]       hs_state,
    output logic             preempt_active
);
    hs_state_e state;
    logic      enabled, timer_load, timer_run, expired;

    assign enabled = glb_en && port_en;

    fp_verify_fsm #(.MAX_RETRY(MAX_RETRY)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enabled       (enabled),
        .link_fail     (link_fail),
        .force_mode    (force_mode),
        .rx_verify     (rx_verify),
        .rx_response   (rx_response),
        .expired       (expired),
        .state         (state),
        .timer_load    (timer_load),
        .timer_run     (timer_run),
        .send_verify   (send_verify),
        .send_response (send_response)
    );

    fp_verify_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (verify_count),
        .run      (timer_run),
        .expired  (expired)
    );

    assign hs_state       = state;
    assign preempt_active = pre_en && enabled && (state == ST_SUCCEEDED || force_mode);

    a_r9_active_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_active |-> (glb_en && port_en && pre_en));

endmodule

// File: tb/fp_verify_ctrl_tb.sv
module fp_verify_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;

    logic        clk = 0, rst_n = 0;
    logic        glb_en = 0, port_en = 0, pre_en = 0, force_mode = 0, link_fail = 1;
    logic [23:0] verify_count = '0;
    logic        rx_verify = 0, rx_response = 0;
    logic        send_verify, send_response, preempt_active;
    logic [2:0]  hs_state;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    fp_verify_ctrl #(.CNT_W(24), .TICK_DIV(DIV), .MAX_RETRY(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .port_en(port_en), .pre_en(pre_en),
        .force_mode(force_mode), .link_fail(link_fail), .verify_count(verify_count),
        .rx_verify(rx_verify), .rx_response(rx_response), .send_verify(send_verify),
        .send_response(send_response), .hs_state(hs_state), .preempt_active(preempt_active));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_gap(int n);
        return n * DIV + 1;
    endfunction

    function automatic bit exp_resp(bit g, bit p, bit lf, bit fm);
        return g && p && !lf && !fm;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // one handshake: resp_at = attempt index that gets a response, 4 = never
    task automatic run_verify(int n, int resp_at);
        int k;
        link_fail = 1;
        step();
        check("R3 state INIT", hs_state, 1);
        check("R3 no tx", {send_verify, send_response}, 0);
        verify_count = 24'(n);
        link_fail = 0;
        step();
        check("R4 state VERIFYING", hs_state, 2);
        check("R4 verify pulse", send_verify, 1);
        for (int a = 0; a < 4; a++) begin
            if (a == resp_at) begin
                rx_response = 1;
                step();
                rx_response = 0;
                check("R6 SUCCEEDED", hs_state, 3);
                check("R9 active in SUCCEEDED", preempt_active, pre_en);
                link_fail = 1;
                step();
                check("R10 back to INIT", hs_state, 1);
                return;
            end
            k = 0;
            do begin
                step();
                k++;
            end while (!send_verify && hs_state == 2 && k < 1000);
            check("R5 gap", k, exp_gap(n));
            if (a < 3) check("R5 retry pulse", send_verify, 1);
            else begin
                check("R5 FAILED", hs_state, 4);
                check("R5 no pulse at fail", send_verify, 0);
            end
        end
        link_fail = 1;
        step();
        check("R10 FAILED to INIT", hs_state, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected 0", cyc);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        #3;
        check("R1 state", hs_state, 0);
        check("R1 outputs", {send_verify, send_response, preempt_active}, 0);
        repeat (2) step();
        rst_n = 1;
        step();
        check("R1 state after reset", hs_state, 0);
        check("R1 outputs after reset", {send_verify, send_response, preempt_active}, 0);

        // R9: pre_en with global enable low has no effect
        pre_en = 1; port_en = 1;
        step();
        check("R2 DISABLED with glb off", hs_state, 0);
        check("R9 pre_en ignored", preempt_active, 0);
        glb_en = 1;
        step();
        check("R2 leaves DISABLED", hs_state, 1);

        // directed corners
        run_verify(0, 4);
        run_verify(1, 0);
        run_verify(3, 4);
        run_verify(2, 3);

        // R7: forced mode
        force_mode = 1; link_fail = 0; verify_count = 24'd0;
        for (int i = 0; i < 10; i++) begin
            step();
            check("R7 no verify", send_verify, 0);
            check("R7 state INIT", hs_state, 1);
            check("R9 forced active", preempt_active, 1);
        end
        rx_verify = 1;
        step();
        rx_verify = 0;
        step();
        check("R8 no response in forced", send_response, 0);
        glb_en = 0;
        step();
        check("R2 disable", hs_state, 0);
        check("R9 inactive when disabled", preempt_active, 0);
        force_mode = 0; glb_en = 1;
        step();
        step();

        // random handshakes
        for (int i = 0; i < 30; i++) begin
            pre_en = 1'($urandom_range(0, 1));
            run_verify(int'($urandom_range(0, 5)), int'($urandom_range(0, 4)));
        end

        // R8: random response requests
        for (int i = 0; i < 200; i++) begin
            bit g, p, lf, fm;
            g  = ($urandom_range(0, 3) != 0);
            p  = ($urandom_range(0, 3) != 0);
            lf = ($urandom_range(0, 2) == 0);
            fm = ($urandom_range(0, 3) == 0);
            glb_en = g; port_en = p; link_fail = lf; force_mode = fm;
            verify_count = 24'($urandom_range(0, 3));
            rx_verify = 1;
            step();
            rx_verify = 0;
            check("R8 response request", send_response, exp_resp(g, p, lf, fm));
            step();
            check("R8 single pulse", send_response, 0);
        end

        done = 1;
        finish_run();
    end
endmodule